// File: doc/BRIEF.md
# Three-Bus Fixed-Priority Access Arbiter

This block sits between three bus masters and three shared memory buses. The masters are a pixel fetcher, a block-copy engine and the processor. The buses are the external bus, the external video bus and the internal object-memory bus. Each master raises a request that names one target bus and says whether it reads or writes. The arbiter picks a winner on every bus in the same cycle, using a fixed priority. It also checks each request against a table of access rights. A request that the table forbids is refused with an error pulse and is never granted.

Every master uses a valid/ready handshake. A master raises `rq_valid` together with its bus selector and write flag, and holds all three stable until the transfer ends. A transfer ends in the cycle where the master sees `rq_ready` (granted) or `rq_error` (refused) high. A master that sees neither is back-pressured: it keeps its request unchanged and tries again on the next cycle. Grant and refusal are decided combinationally from the requests of the current cycle. No state is held between cycles, so the decision is made afresh each cycle.

Top module: `mbus_arbiter`

## Requirements
- R1: On each bus, the pixel fetcher (requester index 0) wins over the copy engine (index 1), and the copy engine wins over the processor (index 2). The lower-priority requester sees `rq_ready` low and `rq_error` low while the higher one holds the bus.
- R2: The pixel fetcher is granted only reads, and only on the video bus (selector 1) or the object-memory bus (selector 2). Any other request from it is refused.
- R3: The copy engine is granted reads on the external bus (selector 0) and the video bus (selector 1) only. A read on the object-memory bus is refused.
- R4: The copy engine is granted writes on the object-memory bus (selector 2) only. A write on selector 0 or 1 is refused.
- R5: The processor may read and write on all of selectors 0, 1 and 2.
- R6: Each bus is arbitrated on its own. Requesters that target different buses are all granted in the same cycle.
- R7: A refused request raises `rq_error` and keeps `rq_ready` low, in the same cycle. A refused request does not keep a lower-priority requester off that bus.
- R8: Selector value 3 names no bus. Any valid request that uses it is refused, whichever requester sends it.
- R9: A legal request that loses arbitration is granted in the first cycle in which no higher-priority legal request targets the same bus.
- R10: While `rst_n` is low, no `rq_ready` or `rq_error` bit is high. In the same state every bus reads idle: `bus_busy` is 0 and `bus_owner` is 3 on every bus.
- R11: For each bus b, `bus_busy[b]` shows whether the bus is granted. `bus_owner[2b+1:2b]` holds the winner's index, or 3 when the bus is idle. `bus_write[b]` holds the winner's write flag, or 0 when the bus is idle.

Bus b is 0 for the external bus, 1 for the video bus and 2 for the object-memory bus. Requester r's selector is `rq_sel[2r+1:2r]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used only to sample the checks |
| rst_n | input | 1 | Active-low reset; while low, all grants and errors are held off |
| rq_valid | input | 3 | Request valid, one bit per requester (bit 0 = pixel fetcher, bit 1 = copy engine, bit 2 = processor) |
| rq_sel | input | 6 | Target-bus selector, two bits per requester |
| rq_write | input | 3 | Write flag per requester: 1 = write, 0 = read |
| rq_ready | output | 3 | Grant per requester; the transfer completes in this cycle |
| rq_error | output | 3 | Refusal pulse per requester; the request breaks the access rights |
| bus_busy | output | 3 | Per-bus flag that the bus is granted this cycle |
| bus_owner | output | 6 | Per-bus index of the winner, 3 when the bus is idle |
| bus_write | output | 3 | Per-bus write flag of the winner |

## Verification
Some patterns put all three requesters on the same bus, with the same direction. These show whether the priority order holds or is inverted. They also show whether a refused high-priority request wrongly blocks the requester below it. Other patterns spread the requesters across different buses, which shows whether the buses are arbitrated independently. Single-requester patterns cover every forbidden bus and direction, plus selector 3, so that each entry in the access-rights table is separated from its neighbours. A directed sequence holds a losing request across the cycle in which the winner withdraws, to check that the loser is granted there. Separate checks cover the per-bus owner and write outputs, and the outputs during reset.

// File: rtl/mbus_arb_pkg.sv
package mbus_arb_pkg;
  localparam int NUM_REQ = 3;
  localparam int NUM_BUS = 3;
  localparam int SEL_W   = 2;
  localparam int OWN_W   = $clog2(NUM_REQ + 1);

  typedef enum logic [SEL_W-1:0] {
    BUS_EXT = 2'd0,
    BUS_VID = 2'd1,
    BUS_OBJ = 2'd2,
    BUS_NONE = 2'd3
  } bus_sel_e;

  localparam int RQ_PIX = 0;
  localparam int RQ_CPY = 1;

  // Access-rights table: returns 1 when the requester may perform the operation.
  function automatic logic access_ok(int unsigned rq, logic [SEL_W-1:0] sel, logic wr);
    logic ok;
    if (int'(sel) >= NUM_BUS) begin
      ok = 1'b0;
    end else begin
      case (rq)
        RQ_PIX:  ok = !wr && (sel == BUS_VID || sel == BUS_OBJ);
        RQ_CPY:  ok = wr ? (sel == BUS_OBJ) : (sel == BUS_EXT || sel == BUS_VID);
        default: ok = 1'b1;
      endcase
    end
    return ok;
  endfunction
endpackage

// File: rtl/mbus_rights.sv
module mbus_rights
  import mbus_arb_pkg::*;
#(
  parameter int REQ_ID = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [SEL_W-1:0] sel,
  input  logic             wr,
  output logic             legal,
  output logic             refused
);
  logic ok;

  always_comb begin
    ok      = access_ok(REQ_ID, sel, wr);
    legal   = rst_n && valid && ok;
    refused = rst_n && valid && !ok;
  end

  // R8: a selector that names no bus is always refused
  assert_bad_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && sel == BUS_NONE) |-> (refused && !legal));
endmodule

// File: rtl/mbus_lane.sv
module mbus_lane
  import mbus_arb_pkg::*;
#(
  parameter int BUS_ID = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_REQ-1:0]       legal,
  input  logic [NUM_REQ*SEL_W-1:0] sel_flat,
  input  logic [NUM_REQ-1:0]       wr,
  output logic [NUM_REQ-1:0]       gnt,
  output logic                     busy,
  output logic [OWN_W-1:0]         owner,
  output logic                     bus_wr
);
  logic [NUM_REQ-1:0] hit;

  always_comb begin
    for (int r = 0; r < NUM_REQ; r++) begin
      hit[r] = legal[r] && (sel_flat[r*SEL_W +: SEL_W] == SEL_W'(BUS_ID));
    end
  end

  // Lowest index has the highest priority.
  always_comb begin
    logic taken;
    taken  = 1'b0;
    gnt    = '0;
    owner  = '1;
    bus_wr = 1'b0;
    for (int r = 0; r < NUM_REQ; r++) begin
      if (hit[r] && !taken) begin
        gnt[r] = 1'b1;
        owner  = OWN_W'(r);
        bus_wr = wr[r];
        taken  = 1'b1;
      end
    end
    busy = taken;
  end

  // R1: a granted requester has no higher-priority competitor on this bus
  for (genvar r = 1; r < NUM_REQ; r++) begin : g_prio_chk
    assert_prio_R1: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[r] |-> (hit[r-1:0] == '0));
  end
endmodule

// File: rtl/mbus_arbiter.sv
module mbus_arbiter
  import mbus_arb_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_REQ-1:0]       rq_valid,
  input  logic [NUM_REQ*SEL_W-1:0] rq_sel,
  input  logic [NUM_REQ-1:0]       rq_write,
  output logic [NUM_REQ-1:0]       rq_ready,
  output logic [NUM_REQ-1:0]       rq_error,
  output logic [NUM_BUS-1:0]       bus_busy,
  output logic [NUM_BUS*OWN_W-1:0] bus_owner,
  output logic [NUM_BUS-1:0]       bus_write
);
  logic [NUM_REQ-1:0]              legal;
  logic [NUM_BUS-1:0][NUM_REQ-1:0] gnt_m;

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
    mbus_rights #(.REQ_ID(r)) u_rights (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid   (rq_valid[r]),
      .sel     (rq_sel[r*SEL_W +: SEL_W]),
      .wr      (rq_write[r]),
      .legal   (legal[r]),
      .refused (rq_error[r])
    );
  end

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    mbus_lane #(.BUS_ID(b)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .legal    (legal),
      .sel_flat (rq_sel),
      .wr       (rq_write),
      .gnt      (gnt_m[b]),
      .busy     (bus_busy[b]),
      .owner    (bus_owner[b*OWN_W +: OWN_W]),
      .bus_wr   (bus_write[b])
    );
  end

  always_comb begin
    rq_ready = '0;
    for (int b = 0; b < NUM_BUS; b++) begin
      rq_ready = rq_ready | gnt_m[b];
    end
  end

  // R2: the pixel fetcher is never granted a write
  assert_pix_read_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rq_ready[RQ_PIX] |-> !rq_write[RQ_PIX]);

  // R4: a granted copy-engine write always targets the object-memory bus
  assert_cpy_write_obj_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_ready[RQ_CPY] && rq_write[RQ_CPY]) |-> (rq_sel[RQ_CPY*SEL_W +: SEL_W] == BUS_OBJ));

  // R7: grant and refusal never coincide for the same requester
  assert_ready_error_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_ready & rq_error) == '0);

  // R11: the number of busy buses equals the number of granted requesters
  assert_busy_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bus_busy) == $countones(rq_ready));
endmodule

// File: tb/sim_mbus_arbiter.sv
module sim_mbus_arbiter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] rq_valid;
  logic [5:0] rq_sel;
  logic [2:0] rq_write;
  logic [2:0] rq_ready;
  logic [2:0] rq_error;
  logic [2:0] bus_busy;
  logic [5:0] bus_owner;
  logic [2:0] bus_write;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  mbus_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .rq_valid(rq_valid), .rq_sel(rq_sel),
    .rq_write(rq_write), .rq_ready(rq_ready), .rq_error(rq_error),
    .bus_busy(bus_busy), .bus_owner(bus_owner), .bus_write(bus_write)
  );

  // {valid, sel{cpu,cpy,pix}, write, expected ready, expected error}
  localparam int NV = 13;
  localparam logic [17:0] VEC [NV] = '{
    {3'b111, 6'b00_00_00, 3'b000, 3'b010, 3'b001},
    {3'b111, 6'b01_01_01, 3'b000, 3'b001, 3'b000},
    {3'b111, 6'b10_10_10, 3'b111, 3'b010, 3'b001},
    {3'b111, 6'b10_00_01, 3'b100, 3'b111, 3'b000},
    {3'b110, 6'b01_01_00, 3'b010, 3'b100, 3'b010},
    {3'b110, 6'b00_10_00, 3'b000, 3'b100, 3'b010},
    {3'b001, 6'b00_00_11, 3'b000, 3'b000, 3'b001},
    {3'b100, 6'b11_00_00, 3'b100, 3'b000, 3'b100},
    {3'b100, 6'b00_00_00, 3'b100, 3'b100, 3'b000},
    {3'b100, 6'b01_00_00, 3'b100, 3'b100, 3'b000},
    {3'b011, 6'b00_00_10, 3'b010, 3'b001, 3'b010},
    {3'b000, 6'b00_00_00, 3'b000, 3'b000, 3'b000},
    {3'b110, 6'b01_01_00, 3'b100, 3'b010, 3'b000}
  };

  function automatic string vec_tag(int i);
    case (i)
      0:  return "R2";
      1:  return "R1";
      2:  return "R4";
      3:  return "R6";
      4:  return "R7";
      5:  return "R3";
      6:  return "R8";
      7:  return "R8";
      8:  return "R5";
      9:  return "R5";
      10: return "R7";
      11: return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic drive(logic [2:0] v, logic [5:0] s, logic [2:0] w);
    @(negedge clk);
    rq_valid = v;
    rq_sel   = s;
    rq_write = w;
    #5;
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    rq_valid = '0; rq_sel = '0; rq_write = '0;
    // R10: nothing granted or refused during reset
    drive(3'b111, 6'b10_00_01, 3'b100);
    check("R10", "ready", {3'b0, rq_ready}, 6'b0);
    check("R10", "error", {3'b0, rq_error}, 6'b0);
    check("R10", "busy",  {3'b0, bus_busy}, 6'b0);
    check("R10", "owner", bus_owner, 6'b11_11_11);
    drive(3'b000, 6'b0, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][17:15], VEC[i][14:9], VEC[i][8:6]);
      check(vec_tag(i), $sformatf("ready vec%0d", i), {3'b0, rq_ready}, {3'b0, VEC[i][5:3]});
      check(vec_tag(i), $sformatf("error vec%0d", i), {3'b0, rq_error}, {3'b0, VEC[i][2:0]});
    end

    // R9: processor stalled behind the pixel fetcher on the video bus
    drive(3'b101, 6'b01_00_01, 3'b000);
    check("R9", "ready while stalled", {3'b0, rq_ready}, 6'b000_001);
    check("R9", "error while stalled", {3'b0, rq_error}, 6'b0);
    check("R11", "video owner pix", {4'b0, bus_owner[3:2]}, 6'd0);
    drive(3'b100, 6'b01_00_01, 3'b000);
    check("R9", "ready after release", {3'b0, rq_ready}, 6'b000_100);
    check("R11", "video owner cpu", {4'b0, bus_owner[3:2]}, 6'd2);
    check("R11", "video write flag", {3'b0, bus_write}, 6'b0);

    // R11: processor write on the object bus, others idle
    drive(3'b100, 6'b10_00_00, 3'b100);
    check("R11", "busy", {3'b0, bus_busy}, 6'b000_100);
    check("R11", "owner", bus_owner, 6'b10_11_11);
    check("R11", "write", {3'b0, bus_write}, 6'b000_100);

    // R11: fully idle
    drive(3'b000, 6'b10_00_00, 3'b100);
    check("R11", "idle busy", {3'b0, bus_busy}, 6'b0);
    check("R11", "idle owner", bus_owner, 6'b11_11_11);
    check("R11", "idle write", {3'b0, bus_write}, 6'b0);

    // R7: refused pixel fetcher does not block the copy engine on the external bus
    drive(3'b011, 6'b00_00_00, 3'b000);
    check("R7", "ext owner cpy", {4'b0, bus_owner[1:0]}, 6'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule